// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between one processor port and its cache controller. It keeps account of the memory requests that have been issued but not yet answered. Every request is identified by its cache-line address, which is the byte address with the in-line offset bits cleared. Requests that modify or reserve a line go into a write-class table. Plain loads and instruction fetches go into a read-class table. A line may have at most one entry across both tables.

Each request gets a response code in the same cycle it is presented. An accepted request is stored with a sequential ID and the value of a free-running cycle counter. A completion names the table and the line. In the same cycle the block returns the stored ID and the elapsed cycles, and frees the entry. A completion that matches no entry is flagged as an orphan. While requests are outstanding, a periodic watchdog scans every entry and latches a deadlock flag if any entry has waited at least the threshold. Four saturating-free counters record rejected requests by the kind of the blocked request and the kind of the blocking entry.

Top module: `req_tracker`

## Requirements
- R1: Kind codes are 0 load, 1 instruction fetch, 2 store, 3 atomic read, 4 atomic write, 5 reserving read and 6 conditional write. Codes 2 to 6 occupy the write table. Codes 0 and 1 occupy the read table.
- R2: A request whose line has an entry in either table gets response code 1 (aliased) and changes no entry. This holds even when the tables are full.
- R3: A request that is not aliased gets code 2 (full) when the outstanding count equals MAX_OUT.
- R4: A request whose offset (address bits below log2(LINE_BYTES)) plus length exceeds LINE_BYTES gets code 3 (bad span). This code takes priority over aliased and full. It changes no entry and no counter. Offset plus length equal to LINE_BYTES is legal.
- R5: Any other request gets code 0 (accepted) and is stored. `req_id` carries its ID. IDs start at 0 after reset and advance by one per accepted request.
- R6: `occ_count` is 0 after reset and always equals the number of stored entries. It is updated on the clock edge after an accept or a completion.
- R7: A completion that matches an entry in the named table asserts `cpl_done` in the same cycle. It returns that entry's ID and the latency, meaning the cycles from the accepting edge to the completing edge. The entry is freed.
- R8: A completion that matches no entry in the named table asserts `cpl_orphan` and leaves all state unchanged.
- R9: While entries are outstanding, a check runs every DL_THRESH cycles. `deadlock` is set if any entry's age is at least DL_THRESH, and stays set until reset. An entry younger than DL_THRESH never sets it.
- R10: The four stall counters start at 0. An aliased request whose line is held in the write table increments `stall_rd_on_wr` if its kind is 0, 1 or 3, and `stall_wr_on_wr` otherwise. A request aliased only in the read table increments `stall_wr_on_rd` if its kind is 2 or 4, and `stall_rd_on_rd` otherwise.
- R11: Two addresses that differ only in their offset bits refer to the same line, both for the alias check and for completion matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented this cycle |
| req_kind | input | 3 | Request kind code |
| req_addr | input | ADDR_W | Byte address of request |
| req_len | input | log2(LINE_BYTES)+1 | Access length in bytes |
| req_code | output | 2 | Response: 0 accepted, 1 aliased, 2 full, 3 bad span |
| req_id | output | ID_W | ID given to the request if accepted |
| cpl_valid | input | 1 | Completion presented this cycle |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_addr | input | ADDR_W | Address of the completed line |
| cpl_done | output | 1 | Completion matched an entry |
| cpl_orphan | output | 1 | Completion matched no entry |
| cpl_id | output | ID_W | ID of the completed entry |
| cpl_latency | output | TS_W | Cycles the entry was outstanding |
| occ_count | output | log2(MAX_OUT+1) | Number of outstanding entries |
| deadlock | output | 1 | Sticky watchdog flag |
| stall_rd_on_rd | output | STALL_W | Reject count, read-kind blocked by read entry |
| stall_rd_on_wr | output | STALL_W | Reject count, read-kind blocked by write entry |
| stall_wr_on_rd | output | STALL_W | Reject count, write-kind blocked by read entry |
| stall_wr_on_wr | output | STALL_W | Reject count, write-kind blocked by write entry |

## Verification
The assertions assume that the kind code is one of the seven defined values. They also assume that no entry stays outstanding for more than 2^TS_W cycles, since ages wrap at that width. The stimulus uses only codes 0 to 6 and completes every early request within a few dozen cycles, well under both limits. Requests and completions are never presented in the same cycle, so each accept or free moves the occupancy by exactly one. Only the final entry is left pending on purpose, to trip the watchdog.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    K_LOAD    = 3'd0,
    K_FETCH   = 3'd1,
    K_STORE   = 3'd2,
    K_ATOM_RD = 3'd3,
    K_ATOM_WR = 3'd4,
    K_RSV_RD  = 3'd5,
    K_CND_WR  = 3'd6
  } kind_e;

  typedef enum logic [1:0] {
    RC_ACCEPT  = 2'd0,
    RC_ALIAS   = 2'd1,
    RC_FULL    = 2'd2,
    RC_BADSPAN = 2'd3
  } rcode_e;

  // Stall counter slots
  localparam int ST_RD_ON_RD = 0;
  localparam int ST_RD_ON_WR = 1;
  localparam int ST_WR_ON_RD = 2;
  localparam int ST_WR_ON_WR = 3;

  // R1: kinds that occupy the write-class table
  function automatic logic uses_wr_table(input logic [2:0] k);
    return (k >= 3'd2) && (k <= 3'd6);
  endfunction

  // R10: kinds counted as readers when blocked by a write entry
  function automatic logic reader_vs_wr(input logic [2:0] k);
    return (k == K_LOAD) || (k == K_FETCH) || (k == K_ATOM_RD);
  endfunction

  // R10: kinds counted as writers when blocked by a read entry
  function automatic logic writer_vs_rd(input logic [2:0] k);
    return (k == K_STORE) || (k == K_ATOM_WR);
  endfunction

endpackage

// File: rtl/rt_table.sv
module rt_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 8,
  parameter int TS_W   = 16,
  parameter int THRESH = 1024,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic [TS_W-1:0]   alloc_ts,
  input  logic              free_en,
  input  logic [LINE_W-1:0] free_line,
  output logic              free_hit,
  output logic [ID_W-1:0]   free_id,
  output logic [TS_W-1:0]   free_ts,
  input  logic [TS_W-1:0]   now,
  output logic              stale_any,
  output logic [CNT_W-1:0]  occ
);

  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  look_vec, free_vec, stale_vec, slot_vec;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [TS_W-1:0]   ts_q   [DEPTH];

  function automatic logic [TS_W-1:0] age_of(input logic [TS_W-1:0] t_now,
                                             input logic [TS_W-1:0] t_then);
    return t_now - t_then;
  endfunction

  // Fully associative compares, one set per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign look_vec[g]  = vld[g] && (line_q[g] == look_line);
    assign free_vec[g]  = vld[g] && (line_q[g] == free_line);
    assign stale_vec[g] = vld[g] && (age_of(now, ts_q[g]) >= TS_W'(THRESH));
  end

  assign look_hit  = |look_vec;
  assign free_hit  = |free_vec;
  assign stale_any = |stale_vec;

  // Lowest free slot
  always_comb begin : pick_slot
    logic taken;
    taken    = 1'b0;
    slot_vec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !taken) begin
        slot_vec[i] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  always_comb begin
    free_id = '0;
    free_ts = '0;
    occ     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_vec[i]) begin
        free_id = free_id | id_q[i];
        free_ts = free_ts | ts_q[i];
      end
      occ = occ + CNT_W'(vld[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
        id_q[i]   <= '0;
        ts_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_en && free_vec[i]) begin
          vld[i] <= 1'b0;
        end else if (alloc_en && slot_vec[i]) begin
          vld[i]    <= 1'b1;
          line_q[i] <= alloc_line;
          id_q[i]   <= alloc_id;
          ts_q[i]   <= alloc_ts;
        end
      end
    end
  end

  // R2: a line is never stored twice
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_vec));

  // R3: allocation only happens with room left
  a_r3_room_on_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !(&vld));

endmodule

// File: rtl/rt_watchdog.sv
module rt_watchdog #(
  parameter int THRESH = 1024,
  localparam int TM_W  = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic busy,
  input  logic stale_any,
  output logic check_now,
  output logic deadlock
);

  logic            armed;
  logic [TM_W-1:0] timer;

  assign check_now = armed && (timer == TM_W'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      timer    <= '0;
      deadlock <= 1'b0;
    end else if (!armed) begin
      if (arm) begin
        armed <= 1'b1;
        timer <= '0;
      end
    end else if (check_now) begin
      timer <= '0;
      if (stale_any) deadlock <= 1'b1;
      if (!busy && !arm) armed <= 1'b0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  // R9: the flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);

  // R9: the flag only rises after a scheduled check
  a_r9_rise_on_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(check_now));

endmodule

// File: rtl/rt_stall_ctr.sv
module rt_stall_ctr #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bump,
  output logic [3:0][W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (bump[i]) cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  // R10: one rejection bumps at most one counter
  a_r10_single_bump: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bump));

endmodule

// File: rtl/req_tracker.sv
module req_tracker
  import rt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 4,
  parameter int ID_W       = 8,
  parameter int TS_W       = 16,
  parameter int DL_THRESH  = 1024,
  parameter int STALL_W    = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = OFF_W + 1,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_kind,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  output logic [1:0]         req_code,
  output logic [ID_W-1:0]    req_id,
  input  logic               cpl_valid,
  input  logic               cpl_is_write,
  input  logic [ADDR_W-1:0]  cpl_addr,
  output logic               cpl_done,
  output logic               cpl_orphan,
  output logic [ID_W-1:0]    cpl_id,
  output logic [TS_W-1:0]    cpl_latency,
  output logic [CNT_W-1:0]   occ_count,
  output logic               deadlock,
  output logic [STALL_W-1:0] stall_rd_on_rd,
  output logic [STALL_W-1:0] stall_rd_on_wr,
  output logic [STALL_W-1:0] stall_wr_on_rd,
  output logic [STALL_W-1:0] stall_wr_on_wr
);

  function automatic logic span_overrun(input logic [OFF_W-1:0] off,
                                        input logic [LEN_W-1:0] len);
    logic [LEN_W:0] end_byte;
    end_byte = {2'b00, off} + {1'b0, len};
    return end_byte > (LEN_W + 1)'(LINE_BYTES);
  endfunction

  function automatic logic [TS_W-1:0] elapsed(input logic [TS_W-1:0] t_now,
                                              input logic [TS_W-1:0] t_then);
    return t_now - t_then;
  endfunction

  // Internal events, named for the assertions
  logic              ev_accept, ev_alias, ev_full, ev_badspan;
  logic              ev_alloc_rd, ev_alloc_wr;
  logic              ev_free_rd, ev_free_wr;
  logic              ev_check;
  logic [LINE_W-1:0] req_line, cpl_line;
  logic              hit_rd, hit_wr;
  logic              fhit_rd, fhit_wr;
  logic [ID_W-1:0]   fid_rd, fid_wr;
  logic [TS_W-1:0]   fts_rd, fts_wr;
  logic              stale_rd, stale_wr;
  logic [CNT_W-1:0]  occ_rd, occ_wr;
  logic [CNT_W-1:0]  occ_q;
  logic [ID_W-1:0]   id_q;
  logic [TS_W-1:0]   now_q;
  logic              is_wr_kind;
  logic [3:0]        bump;
  logic [3:0][STALL_W-1:0] stall_cnt;

  assign req_line   = req_addr[ADDR_W-1:OFF_W];
  assign cpl_line   = cpl_addr[ADDR_W-1:OFF_W];
  assign is_wr_kind = uses_wr_table(req_kind);

  // R4 > R2 > R3 > R5 priority
  always_comb begin
    if (span_overrun(req_addr[OFF_W-1:0], req_len))  req_code = RC_BADSPAN;
    else if (hit_wr || hit_rd)                        req_code = RC_ALIAS;
    else if (occ_q >= CNT_W'(MAX_OUT))                req_code = RC_FULL;
    else                                              req_code = RC_ACCEPT;
  end

  assign ev_accept   = req_valid && (req_code == RC_ACCEPT);
  assign ev_alias    = req_valid && (req_code == RC_ALIAS);
  assign ev_full     = req_valid && (req_code == RC_FULL);
  assign ev_badspan  = req_valid && (req_code == RC_BADSPAN);
  assign ev_alloc_rd = ev_accept && !is_wr_kind;
  assign ev_alloc_wr = ev_accept && is_wr_kind;
  assign ev_free_rd  = cpl_valid && !cpl_is_write;
  assign ev_free_wr  = cpl_valid && cpl_is_write;
  assign req_id      = id_q;

  rt_table #(
    .DEPTH(MAX_OUT), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(DL_THRESH)
  ) rd_tab_i (
    .clk, .rst_n,
    .look_line(req_line), .look_hit(hit_rd),
    .alloc_en(ev_alloc_rd), .alloc_line(req_line), .alloc_id(id_q), .alloc_ts(now_q),
    .free_en(ev_free_rd), .free_line(cpl_line), .free_hit(fhit_rd),
    .free_id(fid_rd), .free_ts(fts_rd),
    .now(now_q), .stale_any(stale_rd), .occ(occ_rd)
  );

  rt_table #(
    .DEPTH(MAX_OUT), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(DL_THRESH)
  ) wr_tab_i (
    .clk, .rst_n,
    .look_line(req_line), .look_hit(hit_wr),
    .alloc_en(ev_alloc_wr), .alloc_line(req_line), .alloc_id(id_q), .alloc_ts(now_q),
    .free_en(ev_free_wr), .free_line(cpl_line), .free_hit(fhit_wr),
    .free_id(fid_wr), .free_ts(fts_wr),
    .now(now_q), .stale_any(stale_wr), .occ(occ_wr)
  );

  // Completion side
  assign cpl_done    = cpl_is_write ? (cpl_valid && fhit_wr) : (cpl_valid && fhit_rd);
  assign cpl_orphan  = cpl_valid && !cpl_done;
  assign cpl_id      = cpl_is_write ? fid_wr : fid_rd;
  assign cpl_latency = elapsed(now_q, cpl_is_write ? fts_wr : fts_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      id_q  <= '0;
      now_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (ev_accept) id_q <= id_q + 1'b1;
      occ_q <= occ_q + CNT_W'(ev_accept) - CNT_W'(cpl_done);
    end
  end
  assign occ_count = occ_q;

  rt_watchdog #(.THRESH(DL_THRESH)) wdog_i (
    .clk, .rst_n,
    .arm(ev_accept), .busy(occ_q != '0), .stale_any(stale_rd || stale_wr),
    .check_now(ev_check), .deadlock(deadlock)
  );

  // Stall attribution
  always_comb begin
    bump = '0;
    if (ev_alias) begin
      if (hit_wr) begin
        if (reader_vs_wr(req_kind)) bump[ST_RD_ON_WR] = 1'b1;
        else                        bump[ST_WR_ON_WR] = 1'b1;
      end else begin
        if (writer_vs_rd(req_kind)) bump[ST_WR_ON_RD] = 1'b1;
        else                        bump[ST_RD_ON_RD] = 1'b1;
      end
    end
  end

  rt_stall_ctr #(.W(STALL_W)) stall_i (
    .clk, .rst_n, .bump(bump), .cnt(stall_cnt)
  );

  assign stall_rd_on_rd = stall_cnt[ST_RD_ON_RD];
  assign stall_rd_on_wr = stall_cnt[ST_RD_ON_WR];
  assign stall_wr_on_rd = stall_cnt[ST_WR_ON_RD];
  assign stall_wr_on_wr = stall_cnt[ST_WR_ON_WR];

  // R6: running count matches the table contents
  a_r6_occ_matches: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, occ_q} == ((CNT_W + 1)'(occ_rd) + (CNT_W + 1)'(occ_wr)));

  // R3: never more than MAX_OUT outstanding
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(MAX_OUT));

  // R4: a bad-span request alone leaves occupancy untouched
  a_r4_badspan_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_badspan && !cpl_valid) |=> $stable(occ_q));

  // R5: IDs advance by one per accept
  a_r5_id_advances: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (req_id == $past(req_id) + 1'b1));

  // R7: a lone completion drops the count by one
  a_r7_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_done && !ev_accept) |=> (occ_q == $past(occ_q) - 1'b1));

  // R8: an orphan completion with no request leaves occupancy alone
  a_r8_orphan_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_orphan && !req_valid) |=> $stable(occ_q));

endmodule

// File: tb/req_tracker_tb_top.sv
module req_tracker_tb_top;

  localparam int THR = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [31:0] req_addr = '0;
  logic [6:0]  req_len = '0;
  logic [1:0]  req_code;
  logic [7:0]  req_id;
  logic        cpl_valid = 1'b0;
  logic        cpl_is_write = 1'b0;
  logic [31:0] cpl_addr = '0;
  logic        cpl_done, cpl_orphan;
  logic [7:0]  cpl_id;
  logic [15:0] cpl_latency;
  logic [2:0]  occ_count;
  logic        deadlock;
  logic [15:0] s_rr, s_rw, s_wr, s_ww;

  req_tracker #(.DL_THRESH(THR)) dut_i (
    .clk, .rst_n, .req_valid, .req_kind, .req_addr, .req_len, .req_code, .req_id,
    .cpl_valid, .cpl_is_write, .cpl_addr, .cpl_done, .cpl_orphan, .cpl_id, .cpl_latency,
    .occ_count, .deadlock,
    .stall_rd_on_rd(s_rr), .stall_rd_on_wr(s_rw), .stall_wr_on_rd(s_wr), .stall_wr_on_wr(s_ww)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  typedef struct { logic [25:0] line; int id; int cyc; } ent_t;
  typedef struct { int code; int id; string tag; } rexp_t;
  typedef struct { int done; int orph; int id; int lat; string tag; } cexp_t;

  ent_t  rd_m[$];
  ent_t  wr_m[$];
  rexp_t rq[$];
  cexp_t cq[$];
  int    next_id = 0;
  int    st[4] = '{0, 0, 0, 0};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find_rd(input logic [25:0] l);
    foreach (rd_m[i]) if (rd_m[i].line == l) return i;
    return -1;
  endfunction

  function automatic int find_wr(input logic [25:0] l);
    foreach (wr_m[i]) if (wr_m[i].line == l) return i;
    return -1;
  endfunction

  // Driver: predicts the response from the requirements and queues it
  task automatic send_req(input int kind, input logic [31:0] addr, input int len,
                          input string tag);
    rexp_t e;
    ent_t  n;
    logic [25:0] l;
    int wi, ri;
    @(negedge clk);
    l  = addr[31:6];
    wi = find_wr(l);
    ri = find_rd(l);
    e.tag = tag;
    e.id  = -1;
    if (int'(addr[5:0]) + len > 64) e.code = 3;
    else if (wi >= 0) begin
      e.code = 1;
      if (kind == 0 || kind == 1 || kind == 3) st[1]++; else st[3]++;
    end else if (ri >= 0) begin
      e.code = 1;
      if (kind == 2 || kind == 4) st[2]++; else st[0]++;
    end else if (rd_m.size() + wr_m.size() >= 4) e.code = 2;
    else begin
      e.code = 0;
      e.id   = next_id;
      n.line = l; n.id = next_id; n.cyc = cyc;
      next_id++;
      if (kind >= 2 && kind <= 6) wr_m.push_back(n); else rd_m.push_back(n);
    end
    rq.push_back(e);
    req_kind  = 3'(kind);
    req_addr  = addr;
    req_len   = 7'(len);
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic send_cpl(input bit is_wr, input logic [31:0] addr, input string tag);
    cexp_t e;
    int    k;
    @(negedge clk);
    k = is_wr ? find_wr(addr[31:6]) : find_rd(addr[31:6]);
    e.tag = tag;
    if (k < 0) begin
      e.done = 0; e.orph = 1; e.id = -1; e.lat = -1;
    end else begin
      e.done = 1; e.orph = 0;
      if (is_wr) begin
        e.id = wr_m[k].id; e.lat = cyc - wr_m[k].cyc; wr_m.delete(k);
      end else begin
        e.id = rd_m[k].id; e.lat = cyc - rd_m[k].cyc; rd_m.delete(k);
      end
    end
    cq.push_back(e);
    cpl_is_write = is_wr;
    cpl_addr     = addr;
    cpl_valid    = 1'b1;
    @(posedge clk);
    #1 cpl_valid = 1'b0;
  endtask

  // Monitor: pops expectations and compares with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (req_valid && rq.size() > 0) begin
        rexp_t e;
        e = rq.pop_front();
        chk({e.tag, " code"}, int'(req_code), e.code);
        if (e.id >= 0) chk({e.tag, " id"}, int'(req_id), e.id);
      end
      if (cpl_valid && cq.size() > 0) begin
        cexp_t e;
        e = cq.pop_front();
        chk({e.tag, " done"}, int'(cpl_done), e.done);
        chk({e.tag, " orphan"}, int'(cpl_orphan), e.orph);
        if (e.done == 1) begin
          chk({e.tag, " id"}, int'(cpl_id), e.id);
          chk({e.tag, " latency"}, int'(cpl_latency), e.lat);
        end
      end
    end
  end

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic chk_stalls(input string tag);
    chk({tag, " rd_on_rd"}, int'(s_rr), st[0]);
    chk({tag, " rd_on_wr"}, int'(s_rw), st[1]);
    chk({tag, " wr_on_rd"}, int'(s_wr), st[2]);
    chk({tag, " wr_on_wr"}, int'(s_ww), st[3]);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R6 reset occ", int'(occ_count), 0);
    chk("R9 reset deadlock", int'(deadlock), 0);
    chk_stalls("R10 reset");

    send_req(0, 32'h0000_1000, 8, "R5 R1 load accept");
    send_req(2, 32'h0000_2040, 4, "R5 R1 store accept");
    send_req(0, 32'h0000_1008, 8, "R2 R11 load on read line");
    send_req(2, 32'h0000_1030, 4, "R2 store on read line");
    send_req(0, 32'h0000_2050, 4, "R2 load on write line");
    send_req(4, 32'h0000_207C, 4, "R4 R2 edge span atomic write");
    send_req(0, 32'h0000_303C, 5, "R4 bad span load");
    send_req(2, 32'h0000_1030, 40, "R4 bad span beats alias");
    settle();
    chk("R6 occ after two", int'(occ_count), 2);
    chk_stalls("R10 after aliases");

    send_req(1, 32'h0000_3000, 16, "R5 R4 fetch to bad-span line");
    send_req(5, 32'h0000_4000, 8, "R5 R1 reserving read");
    settle();
    chk("R6 occ full", int'(occ_count), 4);
    send_req(0, 32'h0000_5000, 8, "R3 full");
    send_req(0, 32'h0000_4010, 8, "R2 R1 alias beats full");
    repeat (5) @(posedge clk);
    send_cpl(1'b1, 32'h0000_4000, "R7 write completion");
    send_cpl(1'b0, 32'h0000_1020, "R7 R11 read completion offset");
    send_cpl(1'b1, 32'h0000_3000, "R8 R1 wrong table");
    send_cpl(1'b0, 32'h0000_9000, "R8 unknown line");
    settle();
    chk("R6 R8 occ after completions", int'(occ_count), 2);
    chk_stalls("R10 after full phase");

    send_req(0, 32'h0000_5000, 8, "R3 room freed");
    repeat (3) @(posedge clk);
    send_cpl(1'b1, 32'h0000_2040, "R7 store completion");
    send_cpl(1'b0, 32'h0000_3000, "R7 fetch completion");
    repeat (7) @(posedge clk);
    send_cpl(1'b0, 32'h0000_5000, "R7 late completion");
    settle();
    chk("R6 occ empty", int'(occ_count), 0);

    send_req(1, 32'h0000_6000, 4, "R5 pending fetch");
    repeat (100) @(posedge clk);
    settle();
    chk("R9 young entry no flag", int'(deadlock), 0);
    repeat (400) @(posedge clk);
    settle();
    chk("R9 old entry flags", int'(deadlock), 1);
    chk("R6 occ pending", int'(occ_count), 1);

    done = 1'b1;
    report();
    $finish;
  end

endmodule